// File: doc/BRIEF.md
# EEPROM Page Write-Commit Controller

This block sits behind the serial front end of an EEPROM. It collects the data bytes of one write command in a page buffer and copies them into the memory array only after the command's STOP. A start pulse loads the full word address. Each data strobe stores one byte at the current page offset and then advances only the offset bits, so the pointer stays inside one page. A burst longer than a page wraps around and overwrites the bytes stored earlier.

Write protect is sampled once, on the STOP pulse. If protect is low, the block enters a write cycle of fixed length and raises `busy_o`; the front end uses it to withhold acknowledges. During the first page-size cycles of that window, the block scans the buffer and writes each byte that received data into the array, one write per cycle. If protect is high at STOP, the buffered bytes are thrown away and a new command is accepted on the next cycle. A cycle counter takes the place of the real programming time.

Top module: `ee_page_commit`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low and `ptr_o` is 0.
- R2: A `start_i` pulse while not busy loads all 15 bits of `addr_i` into `ptr_o` on the next cycle. It also clears every buffered byte of the previous command.
- R3: Each `data_valid_i` strobe in an open command stores `data_i` at offset `ptr_o[5:0]`. It then increments only `ptr_o[5:0]`, modulo 64, and leaves `ptr_o[14:6]` unchanged.
- R4: When more than 64 bytes arrive before STOP, the offset wraps and a later byte replaces the earlier one at the same offset. Only the newest byte at each offset reaches the array.
- R5: `mem_we_o` is never high while `busy_o` is low, so no array write happens before STOP.
- R6: A `stop_i` with `wp_i` low raises `busy_o` on the next cycle. `busy_o` then stays high for exactly WRITE_CYCLES cycles.
- R7: During the write cycle, the block writes only the offsets that received data in the current command. It writes them in ascending offset order, one per cycle, at `mem_addr_o` = {`ptr_o[14:6]`, offset}.
- R8: A `stop_i` with `wp_i` high causes no array write and leaves `busy_o` low. A `start_i` on the very next cycle is accepted. Protection covers every address from 0x0000 to 0x7FFF.
- R9: Changes on `wp_i` after STOP have no effect on a write cycle already started.
- R10: After the write, `ptr_o` holds the address after the last byte received, wrapped within the page.
- R11: While `busy_o` is high, `start_i`, `data_valid_i` and `stop_i` are ignored. `ptr_o` and the buffered contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a write command and loads `addr_i` |
| addr_i | input | 15 | Word address of the command |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | STOP pulse, closes the command |
| wp_i | input | 1 | Write protect, sampled at STOP |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | 15 | Current address pointer |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 15 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
A stale valid bit makes the array receive bytes from an earlier command in the next write cycle. A lost valid bit makes a write missing from that cycle. Either fault shows at the array port within the first 64 busy cycles. A pointer that carries into the upper bits, or that moves during busy, shows on `ptr_o` one cycle after the strobe, and the array addresses then leave the page. A fault in protect sampling or in the busy counter shows as a busy window of the wrong length, or as a busy window where none should be, starting on the cycle after STOP.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV   = 2'd1,
    ST_COMMIT = 2'd2
  } ee_state_e;
endpackage

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [OFF_W-1:0]  off_next;

  assign off_next = ptr_q[OFF_W-1:0] + OFF_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_addr_i;
    end else if (step_i) begin
      // only the page offset advances
      ptr_q <= {ptr_q[ADDR_W-1:OFF_W], off_next};
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_i && (wr_off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (hit) begin
        data_q[g] <= wr_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o  = data_q[rd_off_i];
  assign rd_valid_o = vld_q[rd_off_i];
endmodule

// File: rtl/ee_commit_seq.sv
module ee_commit_seq
  import ee_pkg::*;
#(
  parameter int OFF_W        = 6,
  parameter int WRITE_CYCLES = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             data_valid_i,
  input  logic             stop_i,
  input  logic             wp_i,
  output logic             load_o,
  output logic             accept_o,
  output logic             clr_o,
  output logic             busy_o,
  output logic             scan_o,
  output logic [OFF_W-1:0] scan_off_o
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  ee_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic           go_stop, last;

  assign go_stop  = (st_q == ST_RECV) && stop_i;
  assign last     = (st_q == ST_COMMIT) && (cnt_q == CNT_W'(WRITE_CYCLES - 1));
  assign load_o   = (st_q != ST_COMMIT) && start_i && !go_stop;
  assign accept_o = (st_q == ST_RECV) && data_valid_i && !stop_i && !start_i;
  assign clr_o    = load_o || (go_stop && wp_i) || last;
  assign busy_o   = (st_q == ST_COMMIT);
  assign scan_o   = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_off_o = cnt_q[OFF_W-1:0];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RECV;
      ST_RECV: begin
        if (stop_i) begin
          // protect sampled here only
          st_d  = wp_i ? ST_IDLE : ST_COMMIT;
          cnt_d = '0;
        end
      end
      ST_COMMIT: begin
        if (last) st_d = ST_IDLE;
        else      cnt_d = cnt_q + CNT_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ee_page_commit.sv
module ee_page_commit #(
  parameter int ADDR_W       = 15,
  parameter int OFF_W        = 6,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic             load, accept, clr, scan, rd_valid;
  logic [OFF_W-1:0] scan_off;

  ee_commit_seq #(
    .OFF_W       (OFF_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .data_valid_i(data_valid_i),
    .stop_i      (stop_i),
    .wp_i        (wp_i),
    .load_o      (load),
    .accept_o    (accept),
    .clr_o       (clr),
    .busy_o      (busy_o),
    .scan_o      (scan),
    .scan_off_o  (scan_off)
  );

  ee_addr_ptr #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W)
  ) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_addr_i(addr_i),
    .step_i     (accept),
    .ptr_o      (ptr_o)
  );

  ee_page_buf #(
    .OFF_W (OFF_W),
    .DATA_W(DATA_W)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (accept),
    .wr_off_i  (ptr_o[OFF_W-1:0]),
    .wr_data_i (data_i),
    .rd_off_i  (scan_off),
    .rd_data_o (mem_data_o),
    .rd_valid_o(rd_valid)
  );

  assign mem_we_o   = scan && rd_valid;
  assign mem_addr_o = {ptr_o[ADDR_W-1:OFF_W], scan_off};
endmodule

// File: rtl/ee_page_commit_chk.sv
module ee_page_commit_chk #(
  parameter int ADDR_W       = 15,
  parameter int OFF_W        = 6,
  parameter int WRITE_CYCLES = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              data_valid_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 32'd1;
    else             run_q <= '0;
  end

  AST_NO_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o); // R5
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i))); // R6
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 32'(WRITE_CYCLES))); // R6
  AST_WP_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o); // R8
  AST_STEP_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && data_valid_i && !start_i && !stop_i)
      |=> (ptr_o[ADDR_W-1:OFF_W] == $past(ptr_o[ADDR_W-1:OFF_W]))); // R3
  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ptr_o)); // R11
  AST_WE_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:OFF_W] == ptr_o[ADDR_W-1:OFF_W])); // R7
endmodule

bind ee_page_commit ee_page_commit_chk #(
  .ADDR_W      (ADDR_W),
  .OFF_W       (OFF_W),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .data_valid_i(data_valid_i),
  .stop_i      (stop_i),
  .wp_i        (wp_i),
  .busy_o      (busy_o),
  .ptr_o       (ptr_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/tb_ee_page_commit.sv
module tb_ee_page_commit;
  localparam int CLK_PERIOD = 10;
  localparam int WC         = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dv = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic        busy, mem_we;
  logic [14:0] ptr, mem_addr;
  logic [7:0]  mem_data;

  int checks = 0, errors = 0;
  logic [22:0] exp_q [$];
  logic [14:0] exp_ptr = '0;
  logic [7:0]  mbuf [64];
  logic        mval [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_page_commit #(.WRITE_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .data_valid_i(dv), .data_i(din), .stop_i(stop), .wp_i(wp),
    .busy_o(busy), .ptr_o(ptr), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every array write
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      logic [22:0] e;
      if (!busy) chk(1'b0, "R5 write outside busy", 1, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected write", {mem_addr, mem_data}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({mem_addr, mem_data} == e, "R7 R4 array write", {mem_addr, mem_data}, e);
      end
    end
  end

  task automatic do_start(input logic [14:0] a);
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
    if (!busy) begin
      exp_ptr = a;
      for (int i = 0; i < 64; i++) mval[i] = 1'b0;
    end
    chk(ptr == exp_ptr, "R2 R11 pointer load", ptr, exp_ptr);
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); dv = 1'b1; din = d;
    @(negedge clk); dv = 1'b0;
    if (!busy) begin
      mbuf[exp_ptr[5:0]] = d;
      mval[exp_ptr[5:0]] = 1'b1;
      exp_ptr = {exp_ptr[14:6], exp_ptr[5:0] + 6'd1};
    end
    chk(ptr == exp_ptr, "R3 pointer step", ptr, exp_ptr);
  endtask

  task automatic do_stop(input logic p, input bit toggle_wp);
    int n;
    @(negedge clk); stop = 1'b1; wp = p;
    @(negedge clk); stop = 1'b0;
    if (!p)
      for (int i = 0; i < 64; i++)
        if (mval[i]) exp_q.push_back({exp_ptr[14:6], 6'(i), mbuf[i]});
    for (int i = 0; i < 64; i++) mval[i] = 1'b0;
    chk(busy == !p, p ? "R8 no busy under protect" : "R6 busy rises", busy, !p);
    if (toggle_wp) wp = ~p;
    n = 0;
    while (busy && n < WC + 10) begin
      n++;
      if (n == 5) wp = 1'b1;
      @(negedge clk);
    end
    if (!p) chk(n == WC, "R6 R9 busy length", n, WC);
    wp = 1'b0;
    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    chk(ptr == exp_ptr, "R10 pointer after write", ptr, exp_ptr);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mbuf[i] = '0; mval[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && ptr == 0, "R1 reset state", {busy, mem_we, ptr}, 0);
    rst_n = 1'b1;

    // short burst mid-page
    do_start(15'h1234);
    do_byte(8'hA1); do_byte(8'hB2); do_byte(8'hC3);
    do_stop(1'b0, 1'b0);

    // R4: 70 bytes wrap at top of array, wp toggled during busy (R9)
    do_start(15'h7FFE);
    for (int i = 0; i < 70; i++) do_byte(8'(i + 8'h10));
    do_stop(1'b0, 1'b1);
    chk(ptr == 15'h7FC4, "R4 R10 wrapped pointer", ptr, 15'h7FC4);

    // R8: protected command discarded, next command taken at once
    do_start(15'h0100);
    for (int i = 0; i < 5; i++) do_byte(8'(8'h50 + i));
    do_stop(1'b1, 1'b0);
    do_start(15'h0200);
    do_byte(8'hEE); do_byte(8'hFF);

    // R11: inputs during busy ignored
    @(negedge clk); stop = 1'b1; wp = 1'b0;
    @(negedge clk); stop = 1'b0;
    for (int i = 0; i < 64; i++)
      if (mval[i]) exp_q.push_back({exp_ptr[14:6], 6'(i), mbuf[i]});
    for (int i = 0; i < 64; i++) mval[i] = 1'b0;
    do_start(15'h5555);
    do_byte(8'h77);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(ptr == exp_ptr, "R11 pointer frozen", ptr, exp_ptr);
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, "R11 R7 buffer untouched", exp_q.size(), 0);
    @(negedge clk);
    chk(!busy, "R11 stop ignored while busy", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule